// File: doc/BRIEF.md
# Companded PCM Single-Slot Serial Port

This block carries one 8-bit companded voice sample per frame over a pair of serial lines. It runs on the bit clock. A frame sync pulse sets the start of a 256-bit-period frame. The sample word is organised as a sign bit, a 3-bit chord and a 4-bit step.

On the transmit side, the block latches the parallel sample and the line-code selection when frame sync arrives. It applies the selected bit-inversion pattern and shifts the byte out MSB first in the first eight bit periods. Outside those eight periods the output enable is low, so the line can be tri-stated.

On the receive side, the block samples the serial input on falling edges during the same eight periods. It removes the same inversion pattern and presents the recovered word with a one-clock valid strobe.

Three line codes can be chosen at run time:
- plain sign-magnitude;
- true sign with inverted magnitude;
- inversion of the even-numbered bits.

Top module: `pcm_slot_port`

## Requirements
- R1: The sample word has the sign in bit 7, the chord in bits 6:4 and the step in bits 3:0. It is sent MSB first: bit 7 in period 0 through bit 0 in period 7.
- R2: When frame_sync is high at a rising edge of bclk, the bit period that follows that edge is period 0, and it carries bit 7 of the transmit byte.
- R3: With fmt = 0 the byte on the line equals the sample word unchanged.
- R4: With fmt = 1 the sign bit stays true and the seven magnitude bits are inverted (XOR 0x7F).
- R5: With fmt = 2 the even-numbered bits 0, 2, 4 and 6 are inverted (XOR 0x55).
- R6: fmt = 3 behaves exactly like fmt = 0.
- R7: ser_out_en is high during periods 0 to 7 only, and low during periods 8 to 255. ser_out is 0 whenever ser_out_en is low.
- R8: tx_word and fmt are latched at the frame sync edge. Changes to them later in the frame do not alter the byte being sent or the format used to decode the received byte.
- R9: ser_in is sampled on the falling edge of each of periods 0 to 7, MSB first. At the rising edge that ends period 7, rx_word is loaded with the received byte XOR the frame's mask.
- R10: rx_valid is high for exactly one clock, at the rising edge that ends period 7. rx_word holds its value until the next capture.
- R11: Without a new frame sync, the frame counter wraps after 256 periods and repeats the slot with the latched word. A new frame sync restarts the frame at period 0.
- R12: After reset and before the first frame sync, the outputs are ser_out_en = 0, ser_out = 0, rx_valid = 0 and rx_word = 0. Activity on ser_in has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-period pulse that marks the frame start |
| fmt | input | 2 | Line-code select: 0 plain, 1 magnitude inverted, 2 even bits inverted, 3 plain |
| tx_word | input | 8 | Sample to transmit (sign, chord, step) |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_out_en | output | 1 | High while ser_out carries slot data |
| rx_word | output | 8 | Decoded received sample |
| rx_valid | output | 1 | One-clock strobe when rx_word is updated |

## Verification
The bench changes tx_word and fmt in every transmit cycle of the slot. A design that read them live instead of latching them would send a corrupted byte, or decode with the wrong mask. It runs a frame with no new sync, to catch a counter that stops at 255 or that fails to repeat the slot. Random noise on ser_in outside the slot exposes a receiver that samples beyond bit 7. Every format value, including the unused code 3, is compared against a mask model in the bench, so a swapped or mis-aligned mask shows up as wrong bits on both the transmit and receive sides.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int FRAME = 256
) (
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       frame_sync,
  input  logic [1:0] fmt,
  input  logic [7:0] tx_word,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       ser_out_en,
  output logic [7:0] rx_word,
  output logic       rx_valid
);
  localparam int PW = $clog2(FRAME);
  localparam logic [PW-1:0] LAST = PW'(FRAME - 1);
  localparam logic [PW-1:0] SLOT = PW'(8);

  function automatic logic [7:0] mask_of(input logic [1:0] f);
    case (f)
      2'd1:    mask_of = 8'h7F;
      2'd2:    mask_of = 8'h55;
      default: mask_of = 8'h00;
    endcase
  endfunction

  logic [PW-1:0] pos, nxt;
  logic          synced;
  logic [1:0]    fmt_q;
  logic [7:0]    tx_q, rx_sh, tx_enc;

  assign nxt    = (pos == LAST) ? '0 : pos + 1'b1;
  assign tx_enc = tx_word ^ mask_of(fmt);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      synced     <= 1'b0;
      fmt_q      <= 2'd0;
      tx_q       <= 8'h00;
      ser_out    <= 1'b0;
      ser_out_en <= 1'b0;
      rx_word    <= 8'h00;
      rx_valid   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (synced && pos == SLOT - 1'b1) begin
        rx_word  <= rx_sh ^ mask_of(fmt_q);
        rx_valid <= 1'b1;
      end
      if (frame_sync) begin
        synced     <= 1'b1;
        pos        <= '0;
        fmt_q      <= fmt;
        tx_q       <= tx_enc;
        ser_out    <= tx_enc[7];
        ser_out_en <= 1'b1;
      end else if (synced) begin
        pos <= nxt;
        if (nxt < SLOT) begin
          ser_out    <= tx_q[3'd7 - nxt[2:0]];
          ser_out_en <= 1'b1;
        end else begin
          ser_out    <= 1'b0;
          ser_out_en <= 1'b0;
        end
      end
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n)
      rx_sh <= 8'h00;
    else if (synced && pos < SLOT)
      rx_sh <= {rx_sh[6:0], ser_in};
  end

  // R7
  slot_enable_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    ser_out_en |-> (synced && pos < SLOT));

  // R2
  sync_start_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_sync |=> (ser_out_en && pos == '0 && ser_out == $past(tx_word[7])));

  // R10
  valid_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  rx_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));

  // R12
  presync_quiet_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !synced |-> (!ser_out_en && !rx_valid && !ser_out));
endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
  logic       bclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [7:0] tx_word = 8'h00;
  logic       ser_in = 1'b0;
  logic       ser_out, ser_out_en, rx_valid;
  logic [7:0] rx_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 bclk = ~bclk;

  pcm_slot_port uut (
    .bclk(bclk), .rst_n(rst_n), .frame_sync(frame_sync), .fmt(fmt),
    .tx_word(tx_word), .ser_in(ser_in), .ser_out(ser_out),
    .ser_out_en(ser_out_en), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  function automatic logic [7:0] exp_mask(input logic [1:0] f);
    if (f == 2'd1) return 8'h7F;
    if (f == 2'd2) return 8'h55;
    return 8'h00;
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    if (f == 2'd1) return "R4";
    if (f == 2'd2) return "R5";
    if (f == 2'd3) return "R6";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge bclk);
    #1;
  endtask

  // R1 R2 R8 R9 R10 R11: one frame; w/f are the values expected to be in force
  task automatic run_frame(input logic [7:0] w, input logic [1:0] f,
                           input logic [7:0] rb, input bit sync);
    logic [7:0] line;
    line = w ^ exp_mask(f);
    frame_sync = sync;
    tx_word = w;
    fmt = f;
    ser_in = 1'($urandom);
    step();
    frame_sync = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check("R7 enable in slot", {7'd0, ser_out_en}, 8'd1);
      check(k == 0 ? "R2 first bit" : fmt_tag(f), {7'd0, ser_out}, {7'd0, line[7-k]});
      ser_in = rb[7-k];
      tx_word = 8'($urandom);
      fmt = 2'($urandom);
      step();
    end
    check("R7 released after slot", {7'd0, ser_out_en}, 8'd0);
    check("R10 valid strobe", {7'd0, rx_valid}, 8'd1);
    check("R9 rx decode", rx_word, rb ^ exp_mask(f));
    ser_in = 1'($urandom);
    step();
    check("R10 one-clock strobe", {7'd0, rx_valid}, 8'd0);
    check("R10 rx hold", rx_word, rb ^ exp_mask(f));
    for (int j = 0; j < 246; j++) begin
      ser_in = 1'($urandom);
      step();
      check("R7 released", {6'd0, ser_out_en, ser_out}, 8'd0);
      if (rx_valid) check("R9 no capture outside slot", 8'd1, 8'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] w, rb;
    logic [1:0] f;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      ser_in = 1'($urandom);
      tx_word = 8'($urandom);
      step();
      check("R12 presync outputs", {5'd0, ser_out_en, ser_out, rx_valid}, 8'd0);
      check("R12 presync rx_word", rx_word, 8'h00);
    end
    // directed: each format with a fixed pattern
    run_frame(8'hA5, 2'd0, 8'h3C, 1'b1);
    run_frame(8'hA5, 2'd1, 8'h3C, 1'b1);
    run_frame(8'hA5, 2'd2, 8'h3C, 1'b1);
    run_frame(8'hA5, 2'd3, 8'h3C, 1'b1);
    run_frame(8'h00, 2'd1, 8'hFF, 1'b1);
    run_frame(8'hFF, 2'd2, 8'h00, 1'b1);
    // R11: no new sync, slot repeats with the latched word and format
    run_frame(8'hFF, 2'd2, 8'h81, 1'b0);
    for (int n = 0; n < 40; n++) begin
      w = 8'($urandom);
      f = 2'($urandom);
      rb = 8'($urandom);
      run_frame(w, f, rb, 1'b1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule